// File: doc/BRIEF.md
# Serial Host Register Access Port

This block lets a host controller read and write a bank of sixteen 8-bit registers over a four-wire serial link. The link has an active-low select, a serial clock, a data input and a data output with its own output enable. The host clock is unrelated to the chip clock. The three host inputs pass through two-flop synchronisers, and all edge detection is done with the local clock `clk`. The host must keep each serial clock phase at least four `clk` periods long.

Every transaction opens with a command byte, sent least significant bit first:

| Bit(s) | Meaning |
|---|---|
| 0 | Direction: 1 reads, 0 writes |
| 4:1 | Register address |
| 6:5 | Reserved, must be 0 |
| 7 | Burst |

A plain transaction then moves one data byte. A burst moves all sixteen registers in address order.

Locations 0 to 14 are read/write. They drive the flat `ctrl_regs` output, which the rest of the chip uses. Location 15 is a read-only status register. It captures `status_in` at the moment the command byte completes.

The port carries no streaming data, so it has no valid/ready pair. Flow control is entirely the host's serial clock: no bit moves unless the host clocks it. All other pins are plain levels.

Top module: `hreg_serial_port`

## Requirements
- R1: After reset, every byte of `ctrl_regs` is 0 and `sdo_oe` is low.
- R2: The command byte is taken LSB first on rising serial clock edges. Bit 0 = 1 means read and bit 0 = 0 means write. Bits 4:1 give the address and bit 7 selects burst.
- R3: A plain write stores the next byte, assembled LSB first, into register `a`. Register `a` appears on `ctrl_regs[8a+7:8a]`.
- R4: A plain read puts register `a` on `sdo`, LSB first. Each bit changes after a falling serial clock edge and holds until the next falling edge. `sdo_oe` is high only in the data phase of a read.
- R5: Writes to address 15 have no effect. A read of address 15 returns the `status_in` value held when its command byte completed.
- R6: A burst starts at address 0 whatever the address field holds. The address steps by one per byte and the burst stops after address 15. Later bytes in the same transaction are ignored.
- R7: A command with bit 5 or bit 6 set is ignored. Nothing is written and `sdo_oe` stays low.
- R8: Raising `cs_n` in the middle of a byte discards the partial byte. The next select starts again with a command byte.
- R9: If the eighth rising serial clock edge of a byte arrives in the same `clk` cycle as the release of `cs_n`, the byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock; idles high |
| sdi | input | 1 | Serial data in |
| status_in | input | 8 | Status vector captured into location 15 |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| ctrl_regs | output | 120 | Registers 0 to 14, with register 0 in the low byte |

## Verification
Two events can land in the same `clk` cycle.

- **Release with final edge.** The release of select can coincide with the final rising edge of a write byte. Both inputs pass through synchronisers of equal depth. The bench therefore raises `sclk` and `cs_n` in the same step. It then checks that the target register keeps its old value, and that the next transaction is decoded as a fresh command.
- **Capture with a status change.** The status capture can coincide with a change of `status_in`. The bench changes the status input straight after the command byte and expects the older value back on `sdo`.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int N = 3,
  parameter int DEPTH = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [DEPTH-1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {DEPTH{RST_VAL[g]}};
      else        stage <= {stage[DEPTH-2:0], d_in[g]};
    end
    assign d_out[g] = stage[DEPTH-1];
  end
endmodule

// File: rtl/hrp_shifter.sv
module hrp_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          sclk_s,
  input  logic          sdi_s,
  output logic          byte_done,
  output logic [DW-1:0] byte_val,
  output logic          fall
);
  localparam int BCW = $clog2(DW);

  logic           sclk_d;
  logic [BCW-1:0] bitcnt;
  logic [DW-1:0]  shreg;
  logic           rise;

  assign rise      = sclk_s & ~sclk_d;
  assign fall      = cs_act & ~sclk_s & sclk_d;
  assign byte_val  = {sdi_s, shreg[DW-1:1]};
  assign byte_done = cs_act & rise & (bitcnt == BCW'(DW-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b1;
      bitcnt <= '0;
      shreg  <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (!cs_act) begin
        bitcnt <= '0;
      end else if (rise) begin
        shreg  <= byte_val;
        bitcnt <= (bitcnt == BCW'(DW-1)) ? '0 : bitcnt + 1'b1;
      end
    end
  end

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> bitcnt == '0); // R8
endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     snap_en,
  input  logic [DW-1:0]            status_in,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic [((1<<AW)-1)*DW-1:0] ctrl_flat
);
  localparam int NREG = 1 << AW;
  localparam logic [AW-1:0] RO = AW'(NREG - 1);

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] stat_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == NREG - 1) begin : g_ro
      assign regs[g] = '0;
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[g] <= '0;
        else if (wr_en && wr_addr == AW'(g)) regs[g] <= wr_data;
      end
      assign ctrl_flat[g*DW +: DW] = regs[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (snap_en) stat_q <= status_in;
  end

  always_comb begin
    if (rd_addr == RO) rd_data = snap_en ? status_in : stat_q;
    else               rd_data = regs[rd_addr];
  end

  AST_REGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_flat)); // R3
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(stat_q)); // R5
endmodule

// File: rtl/hreg_serial_port.sv
module hreg_serial_port #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int SYNC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      sclk,
  input  logic                      sdi,
  input  logic [DW-1:0]             status_in,
  output logic                      sdo,
  output logic                      sdo_oe,
  output logic [((1<<AW)-1)*DW-1:0] ctrl_regs
);
  import hrp_pkg::*;

  localparam int NREG = 1 << AW;
  localparam logic [AW-1:0] RO = AW'(NREG - 1);

  logic [2:0]    sync_out;
  logic          cs_s, sclk_s, sdi_s, cs_act;
  logic          byte_done, fall;
  logic [DW-1:0] byte_val;
  phase_t        phase;
  logic          rd_q, burst_q;
  logic [AW-1:0] addr_q, cmd_addr, rd_addr;
  logic [DW-1:0] tx_sh, rd_data;
  logic          sdo_q, cmd_ok, wr_en, snap_en;

  hrp_sync #(.N(3), .DEPTH(SYNC), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({sdi, sclk, cs_n}), .d_out(sync_out)
  );
  assign cs_s   = sync_out[0];
  assign sclk_s = sync_out[1];
  assign sdi_s  = sync_out[2];
  assign cs_act = ~cs_s;

  hrp_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .byte_done(byte_done), .byte_val(byte_val), .fall(fall)
  );

  // Command decode: bit 0 is the direction, bits AW:1 the address,
  // the bits between the address and the top bit are reserved, and the top bit is burst.
  assign cmd_ok   = (byte_val[DW-2:AW+1] == '0);
  assign cmd_addr = byte_val[DW-1] ? '0 : byte_val[AW:1];
  assign rd_addr  = (phase == PH_CMD) ? cmd_addr : addr_q + 1'b1;
  assign snap_en  = byte_done & (phase == PH_CMD) & cmd_ok;
  assign wr_en    = byte_done & (phase == PH_DATA) & ~rd_q;

  hrp_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr_q), .wr_data(byte_val),
    .snap_en(snap_en), .status_in(status_in), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl_flat(ctrl_regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CMD;
      rd_q    <= 1'b0;
      burst_q <= 1'b0;
      addr_q  <= '0;
      tx_sh   <= '0;
      sdo_q   <= 1'b0;
    end else if (!cs_act) begin
      phase <= PH_CMD;
    end else if (byte_done) begin
      case (phase)
        PH_CMD: begin
          if (cmd_ok) begin
            rd_q    <= byte_val[0];
            burst_q <= byte_val[DW-1];
            addr_q  <= cmd_addr;
            tx_sh   <= rd_data;
            phase   <= PH_DATA;
          end else begin
            phase <= PH_DONE;
          end
        end
        PH_DATA: begin
          if (!burst_q || addr_q == RO) begin
            phase <= PH_DONE;
          end else begin
            addr_q <= addr_q + 1'b1;
            tx_sh  <= rd_data;
          end
        end
        default: phase <= PH_DONE;
      endcase
    end else if (fall && phase == PH_DATA && rd_q) begin
      sdo_q <= tx_sh[0];
      tx_sh <= tx_sh >> 1;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = cs_act & (phase == PH_DATA) & rd_q;

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo_q)); // R4
  AST_OE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(byte_done && phase == PH_CMD)); // R4
  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_done && phase == PH_DATA && addr_q == RO) |=> phase != PH_DATA); // R6
  AST_BAD_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_CMD && !cmd_ok) |=> !sdo_oe); // R7
endmodule

// File: tb/tb_hreg_serial_port.sv
module tb_hreg_serial_port;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic sdo, sdo_oe;
  logic [119:0] ctrl_regs;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #5 clk = ~clk;

  hreg_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .status_in(status_in), .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_regs(ctrl_regs)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_tx();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_tx();
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all, output logic oe_any);
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0;
      sdi  = tx[i];
      wait_clk(HALF);
      rx[i]  = sdo;
      oe_all = oe_all & sdo_oe;
      oe_any = oe_any | sdo_oe;
      sclk = 1'b1;
      wait_clk(HALF);
    end
  endtask

  function automatic logic [7:0] cmd(input bit rd, input int a, input bit burst, input logic [1:0] rsv);
    return {burst, rsv, 4'(a), rd};
  endfunction

  task automatic check_regs(input string tag);
    for (int a = 0; a < 15; a++)
      check(tag, 32'(ctrl_regs[a*8 +: 8]), 32'(model[a]));
  endtask

  task automatic single_write(input int a, input logic [7:0] d);
    logic [7:0] rx;
    logic oa, on;
    begin_tx();
    xfer(cmd(1'b0, a, 1'b0, 2'b00), rx, oa, on);
    xfer(d, rx, oa, on);
    check("R4 oe low on write", 32'(on), 0);
    end_tx();
    if (a != 15) model[a] = d;
  endtask

  task automatic single_read(input int a, output logic [7:0] d, output logic oe_all);
    logic [7:0] rx;
    logic oa, on;
    begin_tx();
    xfer(cmd(1'b1, a, 1'b0, 2'b00), rx, oa, on);
    xfer(8'h00, d, oe_all, on);
    end_tx();
  endtask

  initial begin
    logic [7:0] rx, d;
    logic oa, on;

    for (int a = 0; a < 16; a++) model[a] = 8'h00;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R1: reset state
    check_regs("R1 reset regs");
    check("R1 reset oe", 32'(sdo_oe), 0);

    // R2 R3 R5: plain write sweep over every address; address 15 must be ignored
    for (int a = 0; a < 16; a++) single_write(a, 8'((a * 37 + 11) & 8'hFF));
    check_regs("R3 single write sweep");

    // R2 R4 R5: plain read sweep, status location returns status_in
    status_in = 8'h5A;
    model[15] = 8'h5A;
    for (int a = 0; a < 16; a++) begin
      single_read(a, d, oa);
      check("R4 single read data", 32'(d), 32'(model[a]));
      check("R4 oe during read", 32'(oa), 1);
    end

    // R5: status captured when the command byte completes
    status_in = 8'hA5;
    begin_tx();
    xfer(cmd(1'b1, 15, 1'b0, 2'b00), rx, oa, on);
    status_in = 8'h3C;
    xfer(8'h00, d, oa, on);
    end_tx();
    check("R5 status snapshot", 32'(d), 32'hA5);

    // R6: burst write starting from address 0 though the field says 5
    begin_tx();
    xfer(cmd(1'b0, 5, 1'b1, 2'b00), rx, oa, on);
    for (int i = 0; i < 16; i++) begin
      xfer(8'((i * 29 + 200) & 8'hFF), rx, oa, on);
      if (i != 15) model[i] = 8'((i * 29 + 200) & 8'hFF);
    end
    xfer(8'hEE, rx, oa, on);  // R6 byte after the burst ends is ignored
    end_tx();
    check_regs("R6 burst write");

    // R6: burst read with a nonzero address field
    status_in = 8'h96;
    model[15] = 8'h96;
    begin_tx();
    xfer(cmd(1'b1, 9, 1'b1, 2'b00), rx, oa, on);
    for (int i = 0; i < 16; i++) begin
      xfer(8'h00, d, oa, on);
      check("R6 burst read data", 32'(d), 32'(model[i]));
      check("R6 burst read oe", 32'(oa), 1);
    end
    xfer(8'h00, d, oa, on);
    check("R6 oe off after burst", 32'(on), 0);
    end_tx();

    // R7: reserved bits set, write and read both ignored
    for (int r = 1; r < 4; r++) begin
      begin_tx();
      xfer(cmd(1'b0, 3, 1'b0, 2'(r)), rx, oa, on);
      xfer(8'h77, rx, oa, on);
      end_tx();
      begin_tx();
      xfer(cmd(1'b1, 3, 1'b0, 2'(r)), rx, oa, on);
      xfer(8'h00, rx, oa, on);
      end_tx();
      check("R7 reserved read oe", 32'(on), 0);
    end
    check_regs("R7 reserved write ignored");

    // R8: abort part-way through the data byte
    begin_tx();
    xfer(cmd(1'b0, 4, 1'b0, 2'b00), rx, oa, on);
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b0; sdi = 1'b1; wait_clk(HALF);
      sclk = 1'b1; wait_clk(HALF);
    end
    end_tx();
    check_regs("R8 abort mid-byte");
    single_read(4, d, oa);
    check("R8 fresh command after abort", 32'(d), 32'(model[4]));

    // R9: last rising edge together with the release of select
    begin_tx();
    xfer(cmd(1'b0, 2, 1'b0, 2'b00), rx, oa, on);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdi = 1'b1; wait_clk(HALF);
      sclk = 1'b1;
      if (i == 7) cs_n = 1'b1;
      wait_clk(HALF);
    end
    wait_clk(2 * HALF);
    check_regs("R9 coincident release");
    single_write(2, 8'h81);
    check_regs("R9 next transaction decoded");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule